// File: doc/BRIEF.md
# Single-Level Paging Address Translator

This block turns a 16-bit virtual byte address into a 15-bit physical byte address through a directly indexed table of 16 page entries. The top four address bits pick the entry. The low twelve bits pass through unchanged as the offset inside a 4 KB page. Each entry holds a 3-bit frame number, a 2-bit access-rights field, a presence flag, and two usage flags: referenced and modified.

A requester presents an address and a read/write indication together with `req_valid`. In the same cycle the block answers with exactly one of three results: a translated address (`rsp_hit`), a missing-page indication, or a rights violation. On a successful access the block updates the usage flags at the next clock edge. Software loads entries through a write port, clears all referenced flags with a single strobe, and reads back any entry through a combinational read port.

Top module: `paging_xlate`

## Requirements
- R1: After reset every entry reads back with presence, referenced and modified flags at 0, and any accepted request reports a missing page.
- R2: An accepted request to a present entry whose rights allow the access asserts `rsp_hit` in the same cycle, with `rsp_paddr` = {frame number, vaddr[11:0]}.
- R3: An accepted request to an entry whose presence flag is 0 asserts `rsp_page_fault` only, and `rsp_paddr` is 0. This applies whatever the rights field holds.
- R4: Rights bit 0 allows reads and rights bit 1 allows writes. An accepted request to a present entry that lacks the needed bit asserts `rsp_prot_fault` only, and `rsp_paddr` is 0.
- R5: After a hit, the entry's referenced flag reads 1 from the next cycle on. After a write hit, its modified flag also reads 1.
- R6: A request that faults leaves every entry's flags unchanged.
- R7: A table write replaces the frame, rights and presence of the selected entry and clears its referenced and modified flags. While `tbl_we` is high, `req_ready` is 0 and a pending request is neither answered nor applied.
- R8: `clr_ref` clears every referenced flag and leaves the modified flags alone. If a hit is accepted in the same cycle, that page's referenced flag ends at 1.
- R9: Without `req_valid`, `rsp_hit`, `rsp_page_fault` and `rsp_prot_fault` are all 0 and `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle (low during a table write) |
| req_vaddr | input | 16 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Access type not permitted |
| rsp_paddr | output | 15 | Physical byte address, 0 unless hit |
| tbl_we | input | 1 | Load one table entry |
| tbl_idx | input | 4 | Entry to load |
| tbl_frame | input | 3 | Frame number to load |
| tbl_prot | input | 2 | Rights to load (bit0 read, bit1 write) |
| tbl_present | input | 1 | Presence flag to load |
| clr_ref | input | 1 | Clear all referenced flags |
| rd_idx | input | 4 | Entry to read back |
| rd_present | output | 1 | Presence flag of selected entry |
| rd_frame | output | 3 | Frame number of selected entry |
| rd_prot | output | 2 | Rights of selected entry |
| rd_ref | output | 1 | Referenced flag of selected entry |
| rd_mod | output | 1 | Modified flag of selected entry |

## Verification
The assertions assume synchronous inputs that are stable around the sampling edge. They also assume that `req_vaddr` and `req_write` are meaningful whenever `req_valid` is high. The flag-update properties do not depend on a request being held until it is accepted, so a request that meets a table write may simply disappear. The stimulus drives every input only on the falling edge. It mixes directed sequences on pages with each rights setting against random traffic in which requests, table writes and clear strobes collide freely, including a clear that lands on the same cycle as a hit.

// File: rtl/paging_xlate.sv
module paging_xlate #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 15,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  output logic                   rsp_hit,
  output logic                   rsp_page_fault,
  output logic                   rsp_prot_fault,
  output logic [PA_W-1:0]        rsp_paddr,
  input  logic                   tbl_we,
  input  logic [VA_W-OFF_W-1:0]  tbl_idx,
  input  logic [PA_W-OFF_W-1:0]  tbl_frame,
  input  logic [1:0]             tbl_prot,
  input  logic                   tbl_present,
  input  logic                   clr_ref,
  input  logic [VA_W-OFF_W-1:0]  rd_idx,
  output logic                   rd_present,
  output logic [PA_W-OFF_W-1:0]  rd_frame,
  output logic [1:0]             rd_prot,
  output logic                   rd_ref,
  output logic                   rd_mod
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int NPAGES  = 1 << PAGE_W;

  logic [NPAGES-1:0][FRAME_W-1:0] frame_q;
  logic [NPAGES-1:0][1:0]         prot_q;
  logic [NPAGES-1:0]              vld_q, ref_q, mod_q;

  logic [PAGE_W-1:0] pg;
  logic              accept, allowed;

  assign pg        = req_vaddr[VA_W-1:OFF_W];
  assign req_ready = ~tbl_we;
  assign accept    = req_valid & req_ready;
  assign allowed   = req_write ? prot_q[pg][1] : prot_q[pg][0];

  assign rsp_page_fault = accept & ~vld_q[pg];
  assign rsp_prot_fault = accept & vld_q[pg] & ~allowed;
  assign rsp_hit        = accept & vld_q[pg] & allowed;
  assign rsp_paddr      = rsp_hit ? {frame_q[pg], req_vaddr[OFF_W-1:0]} : '0;

  assign rd_present = vld_q[rd_idx];
  assign rd_frame   = frame_q[rd_idx];
  assign rd_prot    = prot_q[rd_idx];
  assign rd_ref     = ref_q[rd_idx];
  assign rd_mod     = mod_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      prot_q  <= '0;
      vld_q   <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
    end else begin
      for (int i = 0; i < NPAGES; i++) begin
        if (tbl_we && tbl_idx == PAGE_W'(i)) begin
          frame_q[i] <= tbl_frame;
          prot_q[i]  <= tbl_prot;
          vld_q[i]   <= tbl_present;
          ref_q[i]   <= 1'b0;
          mod_q[i]   <= 1'b0;
        end else begin
          if (rsp_hit && pg == PAGE_W'(i)) begin
            ref_q[i] <= 1'b1;
            if (req_write) mod_q[i] <= 1'b1;
          end else if (clr_ref) begin
            ref_q[i] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module xlate_checker #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 15,
  parameter int OFF_W = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [VA_W-1:0]               req_vaddr,
  input logic                          req_write,
  input logic                          rsp_hit,
  input logic                          rsp_page_fault,
  input logic                          rsp_prot_fault,
  input logic [PA_W-1:0]               rsp_paddr,
  input logic                          tbl_we,
  input logic                          clr_ref,
  input logic [(1<<(VA_W-OFF_W))-1:0]  ref_q,
  input logic [(1<<(VA_W-OFF_W))-1:0]  mod_q
);
  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_page_fault, rsp_prot_fault}));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_page_fault || rsp_prot_fault) |-> rsp_paddr == '0);

  assert_ref_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |=> ref_q[$past(req_vaddr[VA_W-1:OFF_W])]);

  assert_mod_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && req_write) |=> mod_q[$past(req_vaddr[VA_W-1:OFF_W])]);

  assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tbl_we && !clr_ref && !rsp_hit) |=> ($stable(ref_q) && $stable(mod_q)));

  assert_we_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (!req_ready && !rsp_hit && !rsp_page_fault && !rsp_prot_fault));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !rsp_hit) |=> ref_q == '0);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rsp_hit || rsp_page_fault || rsp_prot_fault));
endmodule

bind paging_xlate xlate_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_xlate_checker (.*);

// File: tb/test_paging_xlate.sv
module test_paging_xlate;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, tbl_we = 0, tbl_present = 0, clr_ref = 0;
  logic [15:0] req_vaddr = 0;
  logic [3:0]  tbl_idx = 0, rd_idx = 0;
  logic [2:0]  tbl_frame = 0;
  logic [1:0]  tbl_prot = 0;
  logic        req_ready, rsp_hit, rsp_page_fault, rsp_prot_fault;
  logic [14:0] rsp_paddr;
  logic        rd_present, rd_ref, rd_mod;
  logic [2:0]  rd_frame;
  logic [1:0]  rd_prot;

  paging_xlate i_paging_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_hit(rsp_hit),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault), .rsp_paddr(rsp_paddr),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_frame(tbl_frame), .tbl_prot(tbl_prot),
    .tbl_present(tbl_present), .clr_ref(clr_ref), .rd_idx(rd_idx),
    .rd_present(rd_present), .rd_frame(rd_frame), .rd_prot(rd_prot),
    .rd_ref(rd_ref), .rd_mod(rd_mod));

  logic [2:0] m_frame [16];
  logic [1:0] m_prot  [16];
  logic       m_vld [16], m_ref [16], m_mod [16];

  int compared = 0, mismatched = 0;
  bit finished = 0;

  function automatic logic [18:0] exp_rsp(logic v, logic [15:0] va, logic w, logic we);
    logic acc, ev, allow, hit;
    logic [3:0] pg;
    pg    = va[15:12];
    acc   = v && !we;
    ev    = m_vld[pg];
    allow = w ? m_prot[pg][1] : m_prot[pg][0];
    hit   = acc && ev && allow;
    return {!we, hit, acc && !ev, acc && ev && !allow, hit ? {m_frame[pg], va[11:0]} : 15'h0};
  endfunction

  function automatic string rsp_tag(logic v, logic [15:0] va, logic w, logic we);
    logic [3:0] pg;
    pg = va[15:12];
    if (we) return "R7";
    if (!v) return "R9";
    if (!m_vld[pg]) return "R3";
    if (!(w ? m_prot[pg][1] : m_prot[pg][0])) return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [15:0] va, logic w, logic we, logic [3:0] wi,
                      logic [2:0] wf, logic [1:0] wp, logic wv, logic clr,
                      logic [3:0] ri, string rtag);
    logic [18:0] e;
    logic acc_hit;
    logic [3:0] pg;
    @(negedge clk);
    req_valid = v; req_vaddr = va; req_write = w;
    tbl_we = we; tbl_idx = wi; tbl_frame = wf; tbl_prot = wp; tbl_present = wv;
    clr_ref = clr; rd_idx = ri;
    #1;
    e = exp_rsp(v, va, w, we);
    check(rsp_tag(v, va, w, we), {13'h0, req_ready, rsp_hit, rsp_page_fault, rsp_prot_fault, rsp_paddr}, {13'h0, e});
    check(rtag, {23'h0, rd_present, rd_frame, rd_prot, rd_ref, rd_mod},
          {23'h0, m_vld[ri], m_frame[ri], m_prot[ri], m_ref[ri], m_mod[ri]});
    acc_hit = e[17];
    pg = va[15:12];
    @(posedge clk);
    if (clr) for (int i = 0; i < 16; i++) m_ref[i] = 0;
    if (acc_hit) begin
      m_ref[pg] = 1;
      if (w) m_mod[pg] = 1;
    end
    if (we) begin
      m_frame[wi] = wf; m_prot[wi] = wp; m_vld[wi] = wv; m_ref[wi] = 0; m_mod[wi] = 0;
    end
  endtask

  task automatic load(logic [3:0] idx, logic [2:0] f, logic [1:0] p, logic vld);
    step(0, 16'h0, 0, 1, idx, f, p, vld, 0, idx, "R7");
  endtask

  task automatic access(logic [15:0] va, logic w, logic [3:0] ri, string rtag);
    step(1, va, w, 0, 4'h0, 3'h0, 2'h0, 0, 0, ri, rtag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = 0; m_prot[i] = 0; m_vld[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state of all entries, and a request faults
    for (int i = 0; i < 16; i++) step(0, 16'h0, 0, 0, 0, 0, 0, 0, 0, 4'(i), "R1");
    access(16'h7FBC, 0, 4'h7, "R1");

    load(4'h7, 3'h5, 2'b11, 1);
    load(4'h2, 3'h3, 2'b01, 1);
    load(4'h9, 3'h1, 2'b10, 1);
    load(4'h4, 3'h6, 2'b11, 0);

    access(16'h7FBC, 0, 4'h7, "R5");   // R2 hit 0x5FBC
    access(16'h0000, 0, 4'h7, "R5");   // page 7 referenced, not modified
    access(16'h2010, 1, 4'h2, "R6");   // R4 write to read-only
    access(16'h4ABC, 0, 4'h2, "R6");   // R3 absent page despite rights; page 2 flags untouched
    access(16'h9000, 0, 4'h4, "R6");   // R4 read to write-only
    access(16'h9123, 1, 4'h9, "R6");   // R2 write hit
    access(16'h0000, 0, 4'h9, "R5");   // page 9 ref and mod set
    step(1, 16'h7001, 0, 1, 4'h3, 3'h2, 2'b01, 1, 0, 4'h7, "R7"); // request blocked by table write
    step(0, 16'h0, 0, 0, 0, 0, 0, 0, 1, 4'h9, "R8");
    access(16'h0000, 0, 4'h9, "R8");   // page 9 ref cleared, mod kept
    access(16'h7004, 0, 4'h7, "R8");
    step(1, 16'h7008, 1, 0, 0, 0, 0, 0, 1, 4'h7, "R8"); // clear with hit on page 7
    access(16'h0000, 0, 4'h7, "R8");   // page 7 ref stays 1
    load(4'h9, 3'h4, 2'b11, 1);
    access(16'h0000, 0, 4'h9, "R7");   // reload cleared flags
    step(0, 16'h9FFF, 1, 0, 0, 0, 0, 0, 0, 4'h9, "R9");

    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom_range(99);
      step(r < 75, 16'($urandom), 1'($urandom), r >= 88, 4'($urandom), 3'($urandom),
           2'($urandom), ($urandom_range(3) != 0), ($urandom_range(19) == 0),
           4'($urandom), "R5");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule